// File: doc/BRIEF.md
# Codec Power-Down and Wake Link Agent

This block is the codec-side state machine of a serial audio link that supports power-down and wake-up. It produces the link bit clock from a local reference oscillator and watches the controller's frame stream. When it sees a write of the power-down bit to the power-down register, it stops the bit clock and pulls its serial return line low. All other traffic is ignored while it sleeps.

While asleep, a local event input can make the agent raise its return line as a wake request. The line stays high until the controller has sent a warm reset and ended it. The agent knows a warm reset because the bit clock is stopped and it can time SYNC high on the oscillator clock against a per-microsecond cycle count. It restarts the bit clock only after it sees SYNC return low. It then waits in a ready state and marks itself ready on its return line in the first frame the controller opens.

Top module: `codec_lp_agent`

## Requirements
- R1: After a synchronous reset, `link_state` is 0 (running), and `bit_clk` and `sdi_out` are low. State codes are: 0 running, 1 asleep, 2 wake requested, 3 warm reset seen, 4 ready.
- R2: In states 0 and 4, `bit_clk` toggles every `HALF_DIV` oscillator cycles, so its period is 2*`HALF_DIV` cycles.
- R3: SYNC and SDATA_OUT are sampled on each falling edge of `bit_clk`. A frame starts at the sample where SYNC is first seen high, and that sample is frame bit 0. A frame is a power-down command when all of these hold: bits 0, 1 and 2 are high (frame and slot valid flags), bit 16 is low (write), bits 17..23 hold address 0x26 MSB first, and bit 39 (data bit 12) is high. At the sample of bit 55 such a frame moves the state to 1 and drives `bit_clk` and `sdi_out` low.
- R4: A frame that differs from the power-down command in the address, the write flag, any valid flag or data bit 12 leaves the state at 0, whatever the other data bits hold.
- R5: In state 1, toggling on SDATA_OUT and SYNC pulses too short for a warm reset leave the state at 1, with `bit_clk` and `sdi_out` low.
- R6: In state 1, a high `wake_evt` moves to state 2 and drives `sdi_out` high. `sdi_out` stays high through states 2 and 3 until the warm reset ends. In state 0, `wake_evt` has no effect.
- R7: In states 1 and 2, SYNC high for `CYC_PER_US` consecutive oscillator cycles is a warm reset and moves to state 3. A shorter pulse changes nothing.
- R8: In state 3, `bit_clk` stays low while SYNC is high. Once SYNC is seen low, the state moves to 4, `sdi_out` goes low and `bit_clk` restarts.
- R9: In states 0 and 4, the sample that opens a frame drives `sdi_out` high until the next falling edge of `bit_clk` (the ready flag). In state 4 it also moves the state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Frame sync / warm reset from the controller |
| sdo_in | input | 1 | Serial data from the controller |
| wake_evt | input | 1 | Local wake event |
| bit_clk | output | 1 | Generated link bit clock |
| sdi_out | output | 1 | Serial return line (ready flag, wake request) |
| link_state | output | 3 | Current state code |

## Verification
The bench builds the agent with `HALF_DIV` = 2 and `CYC_PER_US` = 8. This gives a four-cycle bit clock and an eight-cycle warm-reset threshold, short enough to sweep every threshold pulse length from 1 to 8 cycles. It also sends all 127 non-matching register addresses, and every single data bit apart from the power-down bit, as complete frames. At these values several full sleep, wake and warm-reset rounds fit in a short run, with the bit clock period checked again after each restart.

// File: rtl/codec_lp_pkg.sv
package codec_lp_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLEEP = 3'd1,
    ST_WAKE  = 3'd2,
    ST_WARM  = 3'd3,
    ST_READY = 3'd4
  } link_st_e;

  localparam int TAG_W  = 16;
  localparam int SLOT_W = 20;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
endpackage

// File: rtl/codec_lp_bitclk.sv
module codec_lp_bitclk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bclk,
  output logic fall_stb
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
      bclk  <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      bclk  <= ~bclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign fall_stb = run && (div_q == LAST) && bclk;

  // R2: a high bit clock only drops on a falling strobe while running
  assert_clk_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (run && bclk && !fall_stb) |=> bclk);
endmodule

// File: rtl/codec_lp_framedec.sv
module codec_lp_framedec
  import codec_lp_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PD_ADDR = 7'h26,
  parameter int                PD_BIT  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic smp,
  input  logic sync_in,
  input  logic sdo_in,
  output logic sof,
  output logic pd_hit
);
  localparam int DEC_BITS = TAG_W + 2 * SLOT_W;
  localparam int CW       = $clog2(DEC_BITS + 1);
  localparam logic [CW-1:0] IDLE = CW'(DEC_BITS);
  localparam logic [CW-1:0] LAST = CW'(DEC_BITS - 1);
  localparam int IDX_RW   = TAG_W;
  localparam int IDX_ADR  = TAG_W + 1;
  localparam int IDX_PD   = TAG_W + SLOT_W + (DATA_W - 1 - PD_BIT);

  logic [CW-1:0]       bitcnt_q;
  logic                sync_prev_q;
  logic [DEC_BITS-2:0] sh_q;
  logic [DEC_BITS-1:0] full;
  logic [ADDR_W-1:0]   addr;
  logic                match;

  assign full = {sh_q, sdo_in};
  assign sof  = smp && sync_in && !sync_prev_q;

  always_comb begin
    for (int j = 0; j < ADDR_W; j++)
      addr[ADDR_W-1-j] = full[DEC_BITS-1-(IDX_ADR+j)];
    match = full[DEC_BITS-1] && full[DEC_BITS-2] && full[DEC_BITS-3]
         && !full[DEC_BITS-1-IDX_RW]
         && (addr == PD_ADDR)
         && full[DEC_BITS-1-IDX_PD];
  end

  assign pd_hit = smp && !sof && (bitcnt_q == LAST) && match;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bitcnt_q    <= IDLE;
      sync_prev_q <= 1'b0;
      sh_q        <= '0;
    end else if (smp) begin
      sync_prev_q <= sync_in;
      if (sync_in && !sync_prev_q) begin
        bitcnt_q <= CW'(1);
        sh_q     <= {sh_q[DEC_BITS-3:0], sdo_in};
      end else if (bitcnt_q < IDLE) begin
        bitcnt_q <= bitcnt_q + 1'b1;
        sh_q     <= {sh_q[DEC_BITS-3:0], sdo_in};
      end
    end
  end

  // R3: the frame bit counter never runs past its idle value
  assert_bitcnt_range_R3: assert property (@(posedge clk) disable iff (rst)
    bitcnt_q <= IDLE);
endmodule

// File: rtl/codec_lp_warmdet.sv
module codec_lp_warmdet #(
  parameter int CYC_PER_US = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic sync_in,
  output logic sync_q,
  output logic warm_hit
);
  localparam int HW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [HW-1:0] TOP = HW'(CYC_PER_US - 1);

  logic [HW-1:0] hi_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      sync_q <= sync_in;
      if (!armed || !sync_q)
        hi_cnt_q <= '0;
      else if (hi_cnt_q != TOP)
        hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  assign warm_hit = armed && sync_q && (hi_cnt_q == TOP);

  // R7: a freshly risen sync can never already count as a warm reset
  assert_short_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (CYC_PER_US > 1 && $rose(sync_q)) |-> !warm_hit);
endmodule

// File: rtl/codec_lp_agent.sv
module codec_lp_agent
  import codec_lp_pkg::*;
#(
  parameter int                HALF_DIV   = 4,
  parameter int                CYC_PER_US = 24,
  parameter logic [ADDR_W-1:0] PD_ADDR    = 7'h26,
  parameter int                PD_BIT     = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_in,
  input  logic       sdo_in,
  input  logic       wake_evt,
  output logic       bit_clk,
  output logic       sdi_out,
  output logic [2:0] link_state
);
  link_st_e state_q;
  logic run, armed, smp, sof, pd_hit, sync_q, warm_hit;

  assign run   = (state_q == ST_RUN) || (state_q == ST_READY);
  assign armed = (state_q == ST_SLEEP) || (state_q == ST_WAKE);
  assign link_state = state_q;

  codec_lp_bitclk #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk(clk), .rst(rst), .run(run), .bclk(bit_clk), .fall_stb(smp)
  );

  codec_lp_framedec #(.PD_ADDR(PD_ADDR), .PD_BIT(PD_BIT)) u_dec (
    .clk(clk), .rst(rst), .run(run), .smp(smp), .sync_in(sync_in),
    .sdo_in(sdo_in), .sof(sof), .pd_hit(pd_hit)
  );

  codec_lp_warmdet #(.CYC_PER_US(CYC_PER_US)) u_warm (
    .clk(clk), .rst(rst), .armed(armed), .sync_in(sync_in),
    .sync_q(sync_q), .warm_hit(warm_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      sdi_out <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (pd_hit) begin
            state_q <= ST_SLEEP;
            sdi_out <= 1'b0;
          end else if (sof) sdi_out <= 1'b1;
          else if (smp)     sdi_out <= 1'b0;
        end
        ST_SLEEP: begin
          sdi_out <= 1'b0;
          if (warm_hit) state_q <= ST_WARM;
          else if (wake_evt) begin
            state_q <= ST_WAKE;
            sdi_out <= 1'b1;
          end
        end
        ST_WAKE: if (warm_hit) state_q <= ST_WARM;
        ST_WARM: begin
          if (!sync_q) begin
            state_q <= ST_READY;
            sdi_out <= 1'b0;
          end
        end
        ST_READY: begin
          if (sof) begin
            state_q <= ST_RUN;
            sdi_out <= 1'b1;
          end else if (smp) sdi_out <= 1'b0;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // R5: a sleeping link keeps both of its outputs low
  assert_sleep_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |-> (!bit_clk && !sdi_out));
  // R6: a pending wake request holds the return line high
  assert_wake_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAKE) |-> sdi_out);
  // R8: no clock while the warm reset pulse lasts
  assert_warm_noclk_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM) |-> !bit_clk);
  // R8: ready only after sync has been seen low
  assert_warm_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WARM && sync_q) |=> (state_q == ST_WARM));
endmodule

// File: tb/codec_lp_agent_test.sv
`timescale 1ns/1ps
module codec_lp_agent_test;
  localparam int HALF = 2;
  localparam int CYC  = 8;

  logic clk = 1'b0;
  logic rst, sync_in, sdo_in, wake_evt;
  logic bit_clk, sdi_out;
  logic [2:0] link_state;
  int checks = 0, fails = 0;
  logic cap1, cap2;
  bit done = 0;

  always #4 clk = ~clk;

  codec_lp_agent #(.HALF_DIV(HALF), .CYC_PER_US(CYC)) uut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .sdo_in(sdo_in),
    .wake_evt(wake_evt), .bit_clk(bit_clk), .sdi_out(sdi_out),
    .link_state(link_state)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_frame(input logic [2:0] tv, input logic rw,
                                           input logic [6:0] adr, input logic [15:0] dat);
    return {tv, 13'd0, rw, adr, 12'd0, dat, 4'd0, 8'd0};
  endfunction

  task automatic send_frame(input logic [63:0] v, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(posedge bit_clk); #1;
      if (i == 1) cap1 = sdi_out;
      if (i == 2) cap2 = sdi_out;
      sync_in = (i < 16);
      sdo_in  = v[63-i];
    end
    if (nbits == 64) begin
      @(posedge bit_clk); #1;
      sync_in = 1'b0; sdo_in = 1'b0;
    end
  endtask

  task automatic sync_pulse(input int n);
    @(negedge clk); sync_in = 1'b1;
    repeat (n) @(negedge clk);
    sync_in = 1'b0;
  endtask

  task automatic chk_period(input string req);
    realtime t0, t1;
    @(posedge bit_clk); t0 = $realtime;
    @(posedge bit_clk); t1 = $realtime;
    chk(int'((t1 - t0) / 8.0) == 2*HALF, req, int'((t1 - t0) / 8.0), 2*HALF);
  endtask

  task automatic go_sleep(input logic [15:0] dat);
    send_frame(mk_frame(3'b111, 1'b0, 7'h26, dat), 56);
    repeat (6) @(negedge clk);
    chk(link_state == 3'd1, "R3 state after power-down", link_state, 1);
    chk(!bit_clk && !sdi_out, "R3 outputs low", {bit_clk, sdi_out}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bad;
    rst = 1'b1; sync_in = 1'b0; sdo_in = 1'b0; wake_evt = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    // R1: reset state
    chk(link_state == 3'd0, "R1 state", link_state, 0);
    chk(bit_clk == 1'b0, "R1 bit_clk", bit_clk, 0);
    chk(sdi_out == 1'b0, "R1 sdi_out", sdi_out, 0);
    // R2: bit clock period
    chk_period("R2 period after reset");
    // R9: ready flag in first tag bit, R4: every other address ignored
    bad = 0;
    for (int a = 0; a < 128; a++) begin
      if (a == 'h26) continue;
      send_frame(mk_frame(3'b111, 1'b0, 7'(a), 16'hFFFF), 64);
      @(negedge clk);
      if (link_state != 3'd0) bad++;
      if (a == 0) begin
        chk(cap1 == 1'b1, "R9 ready flag high", cap1, 1);
        chk(cap2 == 1'b0, "R9 ready flag one bit", cap2, 0);
      end
    end
    chk(bad == 0, "R4 address sweep stays running", bad, 0);
    // R4: single data bits other than the power-down bit
    bad = 0;
    for (int b = 0; b < 16; b++) begin
      if (b == 12) continue;
      send_frame(mk_frame(3'b111, 1'b0, 7'h26, 16'(1 << b)), 64);
      @(negedge clk);
      if (link_state != 3'd0) bad++;
    end
    chk(bad == 0, "R4 data bit sweep stays running", bad, 0);
    send_frame(mk_frame(3'b111, 1'b0, 7'h26, 16'hEFFF), 64);
    @(negedge clk);
    chk(link_state == 3'd0, "R4 bit 12 clear", link_state, 0);
    send_frame(mk_frame(3'b111, 1'b1, 7'h26, 16'h1000), 64);
    @(negedge clk);
    chk(link_state == 3'd0, "R4 read command", link_state, 0);
    for (int t = 0; t < 3; t++) begin
      send_frame(mk_frame(3'b111 & ~(3'b100 >> t), 1'b0, 7'h26, 16'h1000), 64);
      @(negedge clk);
      chk(link_state == 3'd0, "R4 valid flag missing", link_state, 0);
    end
    // R6: wake event ignored while running
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    repeat (4) @(negedge clk);
    chk(link_state == 3'd0 && !sdi_out, "R6 wake ignored in run", link_state, 0);
    // R3: power-down
    go_sleep(16'h1000);
    // R5: rest of the frame and short sync ignored
    bad = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); sdo_in = k[0];
      if (bit_clk || sdi_out || link_state != 3'd1) bad++;
    end
    sdo_in = 1'b0;
    chk(bad == 0, "R5 data ignored asleep", bad, 0);
    // R7: pulse length sweep below threshold
    for (int n = 1; n < CYC; n++) begin
      sync_pulse(n);
      repeat (4) @(negedge clk);
      chk(link_state == 3'd1 && !bit_clk, "R7 short sync ignored", link_state, 1);
    end
    // R6: wake request held
    @(negedge clk); wake_evt = 1'b1; @(negedge clk); wake_evt = 1'b0;
    repeat (40) @(negedge clk);
    chk(link_state == 3'd2, "R6 wake state", link_state, 2);
    chk(sdi_out == 1'b1, "R6 wake line high", sdi_out, 1);
    // R7/R8: warm reset while line held
    @(negedge clk); sync_in = 1'b1;
    repeat (CYC + 6) @(negedge clk);
    chk(link_state == 3'd3, "R7 warm reset seen", link_state, 3);
    chk(sdi_out == 1'b1, "R6 line held in warm", sdi_out, 1);
    chk(bit_clk == 1'b0, "R8 no clock while sync high", bit_clk, 0);
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
    chk(link_state == 3'd4, "R8 ready after sync low", link_state, 4);
    chk(sdi_out == 1'b0, "R8 line dropped", sdi_out, 0);
    chk_period("R8 clock restarted");
    // R9: first frame opens run state with ready flag
    send_frame(mk_frame(3'b000, 1'b0, 7'h00, 16'h0000), 64);
    @(negedge clk);
    chk(cap1 == 1'b1, "R9 ready flag from ready", cap1, 1);
    chk(link_state == 3'd0, "R9 back to run", link_state, 0);
    // R7: controller-initiated warm reset at exactly the threshold
    go_sleep(16'hFFFF);
    sync_pulse(CYC);
    repeat (4) @(negedge clk);
    chk(link_state == 3'd4, "R7 threshold pulse", link_state, 4);
    chk(sdi_out == 1'b0, "R7 line low without request", sdi_out, 0);
    chk_period("R2 period after second wake");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule